// File: doc/BRIEF.md
# Host Wake Access Handshake Controller

This block decides when a host may reach the internal resources of a device whose processor domain is power gated. The host drives it through one 32-bit control word. Three bits in that word are writable: a flag that marks the device as fully initialised, a request that holds the internal domain awake, and a crystal-on request. The rest of the word reports status: the clock-ready flag, the going-to-sleep flag, a 3-bit power-save code and the synchronised level of an external radio-kill switch.

A small power state machine runs the wake and sleep sequence. A power manager model supplies a sleep request and a power-up-done acknowledge. A programmable delay counter stands in for the time the clock takes to come up. The `access_grant` output gates internal accesses. It is high only while the clock is ready and no sleep transition is under way. Pulse outputs mark each rise of clock-ready and each change of the radio-kill input.

Control word layout, in bits:

- 0 is clock ready.
- 2 is init-done.
- 3 is the access request.
- 4 is going to sleep.
- 10 is the crystal request.
- 26:24 is the power-save code.
- 27 is the radio-kill level.

All other bits read 0.

Top module: `wake_access_ctrl`

## Requirements
- R1: After reset the control word reads 0x0100_0000, which means only the power-save code 001 is set. In the same state `access_grant`, `wake_evt`, `rfkill_evt` and `xtal_on_req` are all 0.
- R2: Clock-ready (bit 0) stays 0 while init-done (bit 2) is 0. After a write that sets init-done, and with power-up-done high, clock-ready rises exactly `pwrup_delay`+2 cycles after the written value becomes visible.
- R3: A write stores only bits 2, 3 and 10 and ignores every other written bit. A write of bit 10 alone sets bit 10 and `xtal_on_req` and leaves clock-ready at 0.
- R4: `access_grant` is 1 exactly when clock-ready is 1 and going-to-sleep (bit 4) is 0.
- R5: Going-to-sleep rises only in the cycle after both the sleep request is high and the access request is clear. While the access request is held, a sleep request leaves the device awake.
- R6: If the access request is seen during going-to-sleep, the transition is aborted. In the next cycle the device is awake with going-to-sleep at 0 and clock-ready at 1.
- R7: If no abort occurs, going-to-sleep lasts SLEEP_CYC+1 cycles and then clock-ready drops with power-save code 001. Dropping the sleep request restarts the power-up delay, and clock-ready rises again `pwrup_delay`+1 cycles after the cycle in which the request is seen low.
- R8: `wake_evt` is a one-cycle pulse in the first cycle of each clock-ready high period.
- R9: The power-save code (bits 26:24) reads as follows:
  - 000 while awake;
  - 010 while awake with `radio_pd` high;
  - 001 when powered down or waking;
  - 011 after a power-up timeout.
- R10: Bit 27 follows `rfkill_in` through a SYNC_STAGES flop synchroniser. Each change of that synchronised level raises `rfkill_evt` for exactly one cycle, in the cycle the new level appears.
- R11: Clearing init-done returns the device to low power: one cycle after the cleared bit is visible, clock-ready and going-to-sleep are 0 and the code is 001.
- R12: If power-up-done stays low, the power-save code becomes 011 exactly `pwrup_delay`+TMO_CYC+2 cycles after init-done becomes visible, and clock-ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read value (status plus stored bits) |
| pwrup_delay | input | DLY_W | Modelled clock power-up delay, in cycles |
| pm_sleep_req | input | 1 | Power manager asks the domain to sleep |
| pm_pwrup_done | input | 1 | Power manager acknowledges power is up |
| radio_pd | input | 1 | Radio is powered down while the MAC is awake |
| rfkill_in | input | 1 | Asynchronous external radio-kill switch |
| access_grant | output | 1 | Internal accesses permitted |
| wake_evt | output | 1 | Pulse when clock-ready rises |
| rfkill_evt | output | 1 | Pulse when the synchronised radio-kill level changes |
| xtal_on_req | output | 1 | Stored crystal-on request |

## Verification
Every result has a fixed latency from the cycle an input is driven:
- A written bit reads back one cycle later.
- A control transition follows one cycle after that.
- Clock-ready waits a further `pwrup_delay`+1 cycles after the state machine leaves its dark state. A sleep entry waits SLEEP_CYC+1 cycles before going dark.
- Radio-kill changes appear two cycles after the input changes.

For each stimulus, the driver calculates the absolute cycle numbers of these edges. It queues a masked expectation for the cycle just before each edge and for the edge cycle itself, so an early or late transition by one cycle shows up as a miscompare. The monitor samples on the falling clock and compares each item only in the cycle it names.

// File: rtl/wake_pkg.sv
package wake_pkg;

   // Control word positions decoded by the host software
   localparam int unsigned BIT_CLK_RDY  = 0;
   localparam int unsigned BIT_INIT     = 2;
   localparam int unsigned BIT_ACC_REQ  = 3;
   localparam int unsigned BIT_GTS      = 4;
   localparam int unsigned BIT_XTAL     = 10;
   localparam int unsigned PS_LSB       = 24;
   localparam int unsigned BIT_RFKILL   = 27;

   localparam logic [31:0] HOST_WR_MASK =
      (32'd1 << BIT_INIT) | (32'd1 << BIT_ACC_REQ) | (32'd1 << BIT_XTAL);

   typedef enum logic [2:0] {
      PS_NONE   = 3'b000,
      PS_MAC_PD = 3'b001,
      PS_RF_PD  = 3'b010,
      PS_ERROR  = 3'b011
   } ps_code_e;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_WAKING,
      ST_AWAKE,
      ST_GOSLEEP,
      ST_ASLEEP,
      ST_ERROR
   } pwr_state_e;

endpackage

// File: rtl/wake_sync_edge.sv
module wake_sync_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level_out,
   output logic change_evt
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("wake_sync_edge: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= async_in;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b0;
         else        sync_q[s] <= sync_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   assign level_out  = sync_q[SYNC_STAGES-1];
   assign change_evt = sync_q[SYNC_STAGES-1] ^ last_q;

   AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      change_evt && level_out |=> !change_evt || !level_out); // R10

endmodule

// File: rtl/wake_pwr_fsm.sv
module wake_pwr_fsm
   import wake_pkg::*;
#(
   parameter int unsigned DLY_W     = 8,
   parameter int unsigned SLEEP_CYC = 4,
   parameter int unsigned TMO_CYC   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_done,
   input  logic             acc_req,
   input  logic [DLY_W-1:0] pwrup_delay,
   input  logic             pm_sleep_req,
   input  logic             pm_pwrup_done,
   input  logic             radio_pd,
   output logic             clk_rdy,
   output logic             going_sleep,
   output logic [2:0]       ps_code
);

   localparam int unsigned CNT_MAX = (1 << DLY_W) + TMO_CYC + SLEEP_CYC;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dly
      $error("wake_pwr_fsm: DLY_W out of range");
   end
   if (SLEEP_CYC < 1) begin : g_bad_sleep
      $error("wake_pwr_fsm: SLEEP_CYC must be nonzero");
   end

   pwr_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] dly_ext, tmo_lim;

   assign dly_ext = CNT_W'(pwrup_delay);
   assign tmo_lim = dly_ext + CNT_W'(TMO_CYC);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q + 1'b1;
      if (!init_done) begin
         state_d = ST_OFF;
         cnt_d   = '0;
      end else begin
         unique case (state_q)
            ST_OFF: begin
               state_d = ST_WAKING;
               cnt_d   = '0;
            end
            ST_WAKING: begin
               if (cnt_q >= dly_ext && pm_pwrup_done) begin
                  state_d = ST_AWAKE;
                  cnt_d   = '0;
               end else if (cnt_q >= tmo_lim) begin
                  state_d = ST_ERROR;
                  cnt_d   = '0;
               end
            end
            ST_AWAKE: begin
               cnt_d = '0;
               if (pm_sleep_req && !acc_req) state_d = ST_GOSLEEP;
            end
            ST_GOSLEEP: begin
               if (acc_req || !pm_sleep_req) begin
                  state_d = ST_AWAKE;
                  cnt_d   = '0;
               end else if (cnt_q >= CNT_W'(SLEEP_CYC)) begin
                  state_d = ST_ASLEEP;
                  cnt_d   = '0;
               end
            end
            ST_ASLEEP: begin
               cnt_d = '0;
               if (acc_req || !pm_sleep_req) state_d = ST_WAKING;
            end
            default: cnt_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign clk_rdy     = (state_q == ST_AWAKE) || (state_q == ST_GOSLEEP);
   assign going_sleep = (state_q == ST_GOSLEEP);

   always_comb begin
      unique case (state_q)
         ST_AWAKE, ST_GOSLEEP: ps_code = radio_pd ? PS_RF_PD : PS_NONE;
         ST_ERROR:             ps_code = PS_ERROR;
         default:              ps_code = PS_MAC_PD;
      endcase
   end

   AST_NO_RDY_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |=> !clk_rdy); // R2

   AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(going_sleep) |-> $past(pm_sleep_req && !acc_req)); // R5

   AST_ABORT_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      going_sleep && acc_req && init_done |=> !going_sleep && clk_rdy); // R6

   AST_RDY_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_rdy) |-> $past(pm_pwrup_done)); // R12

endmodule

// File: rtl/wake_ctrl_regs.sv
module wake_ctrl_regs
   import wake_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [31:0] reg_wdata,
   input  logic        clk_rdy,
   input  logic        going_sleep,
   input  logic [2:0]  ps_code,
   input  logic        rfkill_lvl,
   output logic [31:0] reg_rdata,
   output logic        init_done,
   output logic        acc_req,
   output logic        xtal_req
);

   logic [31:0] host_q;
   logic [31:0] status_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      host_q <= '0;
      else if (reg_we) host_q <= reg_wdata & HOST_WR_MASK;
   end

   always_comb begin
      status_w                       = '0;
      status_w[BIT_CLK_RDY]          = clk_rdy;
      status_w[BIT_GTS]              = going_sleep;
      status_w[PS_LSB +: 3]          = ps_code;
      status_w[BIT_RFKILL]           = rfkill_lvl;
   end

   assign reg_rdata = (host_q & HOST_WR_MASK) | (status_w & ~HOST_WR_MASK);
   assign init_done = host_q[BIT_INIT];
   assign acc_req   = host_q[BIT_ACC_REQ];
   assign xtal_req  = host_q[BIT_XTAL];

   AST_RO_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_rdata[31:28] == 4'h0) && !reg_rdata[1]); // R3

endmodule

// File: rtl/wake_access_ctrl.sv
module wake_access_ctrl
   import wake_pkg::*;
#(
   parameter int unsigned DLY_W       = 8,
   parameter int unsigned SLEEP_CYC   = 4,
   parameter int unsigned TMO_CYC     = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic [DLY_W-1:0] pwrup_delay,
   input  logic             pm_sleep_req,
   input  logic             pm_pwrup_done,
   input  logic             radio_pd,
   input  logic             rfkill_in,
   output logic             access_grant,
   output logic             wake_evt,
   output logic             rfkill_evt,
   output logic             xtal_on_req
);

   logic       init_done, acc_req;
   logic       clk_rdy, going_sleep;
   logic [2:0] ps_code;
   logic       rfkill_lvl;
   logic       rdy_last_q;

   wake_ctrl_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_we      (reg_we),
      .reg_wdata   (reg_wdata),
      .clk_rdy     (clk_rdy),
      .going_sleep (going_sleep),
      .ps_code     (ps_code),
      .rfkill_lvl  (rfkill_lvl),
      .reg_rdata   (reg_rdata),
      .init_done   (init_done),
      .acc_req     (acc_req),
      .xtal_req    (xtal_on_req)
   );

   wake_pwr_fsm #(
      .DLY_W     (DLY_W),
      .SLEEP_CYC (SLEEP_CYC),
      .TMO_CYC   (TMO_CYC)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .init_done     (init_done),
      .acc_req       (acc_req),
      .pwrup_delay   (pwrup_delay),
      .pm_sleep_req  (pm_sleep_req),
      .pm_pwrup_done (pm_pwrup_done),
      .radio_pd      (radio_pd),
      .clk_rdy       (clk_rdy),
      .going_sleep   (going_sleep),
      .ps_code       (ps_code)
   );

   wake_sync_edge #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rfkill (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (rfkill_in),
      .level_out  (rfkill_lvl),
      .change_evt (rfkill_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy_last_q <= 1'b0;
      else        rdy_last_q <= clk_rdy;
   end

   assign wake_evt     = clk_rdy & ~rdy_last_q;
   assign access_grant = clk_rdy & ~going_sleep;

   AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> !wake_evt); // R8

   AST_GRANT_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      access_grant |-> reg_rdata[BIT_CLK_RDY] && !reg_rdata[BIT_GTS]); // R4

endmodule

// File: tb/wake_access_ctrl_tb.sv
module wake_access_ctrl_tb;

   localparam int DLY_W = 8;
   localparam int SCYC  = 4;
   localparam int TMO   = 16;
   localparam int DLY   = 3;

   localparam logic [63:0] M_RDY   = 64'h1;
   localparam logic [63:0] M_INIT  = 64'h4;
   localparam logic [63:0] M_GTS   = 64'h10;
   localparam logic [63:0] M_XTAL  = 64'h400;
   localparam logic [63:0] M_PS    = 64'h0700_0000;
   localparam logic [63:0] M_RFK   = 64'h0800_0000;
   localparam logic [63:0] M_WORD  = 64'hFFFF_FFFF;
   localparam logic [63:0] M_GRANT = 64'h1 << 32;
   localparam logic [63:0] M_WAKE  = 64'h1 << 33;
   localparam logic [63:0] M_RFEVT = 64'h1 << 34;
   localparam logic [63:0] M_XOUT  = 64'h1 << 35;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_we = 1'b0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic [DLY_W-1:0] pwrup_delay = DLY_W'(DLY);
   logic             pm_sleep_req = 1'b0;
   logic             pm_pwrup_done = 1'b1;
   logic             radio_pd = 1'b0;
   logic             rfkill_in = 1'b0;
   logic             access_grant, wake_evt, rfkill_evt, xtal_on_req;

   wake_access_ctrl #(.DLY_W(DLY_W), .SLEEP_CYC(SCYC), .TMO_CYC(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pwrup_delay(pwrup_delay),
      .pm_sleep_req(pm_sleep_req), .pm_pwrup_done(pm_pwrup_done),
      .radio_pd(radio_pd), .rfkill_in(rfkill_in),
      .access_grant(access_grant), .wake_evt(wake_evt),
      .rfkill_evt(rfkill_evt), .xtal_on_req(xtal_on_req));

   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int          at;
      logic [63:0] mask;
      logic [63:0] val;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   function automatic logic [63:0] obs();
      return {28'd0, xtal_on_req, rfkill_evt, wake_evt, access_grant, reg_rdata};
   endfunction

   task automatic expect_at(int at, logic [63:0] mask, logic [63:0] val, string tag);
      exp_t e;
      e.at = at; e.mask = mask; e.val = val & mask; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compares each queued item in the cycle it names
   always @(negedge clk) begin
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
         if (exp_q[i].at <= cyc) begin
            n_chk++;
            if (exp_q[i].at < cyc || (obs() & exp_q[i].mask) !== exp_q[i].val) begin
               n_bad++;
               $display("FAIL %s cyc=%0d actual=%h expected=%h", exp_q[i].tag,
                        cyc, obs() & exp_q[i].mask, exp_q[i].val);
            end
            exp_q.delete(i);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_wr(logic [31:0] d);
      reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   initial begin
      int k;
      step(3);
      rst_n = 1'b1;
      step(2);

      // R1 reset state
      expect_at(cyc, M_WORD | M_GRANT | M_WAKE | M_RFEVT | M_XOUT,
                64'h0100_0000, "R1 reset word");
      step(1);

      // R3 writes to read-only / unused bits ignored
      k = cyc; host_wr(32'hFFFF_FBF3);
      expect_at(k + 1, M_WORD | M_XOUT, 64'h0100_0000, "R3 ignored bits");
      expect_at(k + 4, M_RDY, 64'h0, "R3 no wake from ignored bits");
      step(5);
      k = cyc; host_wr(32'h0000_0400);
      expect_at(k + 1, M_XTAL | M_XOUT | M_RDY, M_XTAL | M_XOUT, "R3 xtal request");
      expect_at(k + 4, M_RDY | M_XTAL, M_XTAL, "R3 xtal keeps clock off");
      step(5);

      // R2 init-done wakes after the programmed delay; R8 wake pulse
      k = cyc; host_wr(32'h0000_0004);
      expect_at(k + 1, M_INIT | M_RDY | M_XTAL, M_INIT, "R2 init visible, clock off");
      expect_at(k + 2 + DLY, M_RDY | M_GRANT | M_PS, 64'h0100_0000, "R2 still waking");
      expect_at(k + 3 + DLY, M_RDY | M_GRANT | M_WAKE | M_PS,
                M_RDY | M_GRANT | M_WAKE, "R2 R8 R9 clock ready, pulse, code 000");
      expect_at(k + 4 + DLY, M_WAKE | M_RDY, M_RDY, "R8 pulse one cycle");
      step(DLY + 6);

      // R5 access request holds device awake against sleep request
      k = cyc; host_wr(32'h0000_000C);
      step(1);
      pm_sleep_req = 1'b1;
      expect_at(k + 3, M_GTS | M_GRANT, M_GRANT, "R5 request blocks sleep");
      expect_at(k + 5, M_GTS | M_GRANT, M_GRANT, "R5 request blocks sleep later");
      step(5);
      k = cyc; host_wr(32'h0000_0004);
      expect_at(k + 1, M_GTS, 64'h0, "R5 not yet sleeping");
      expect_at(k + 2, M_GTS | M_RDY | M_GRANT, M_GTS | M_RDY, "R5 R4 going to sleep, grant off");
      step(1);

      // R6 abort by access request during going-to-sleep
      k = cyc; host_wr(32'h0000_000C);
      expect_at(k + 1, M_GTS, M_GTS, "R6 still going to sleep");
      expect_at(k + 2, M_GTS | M_RDY | M_GRANT, M_RDY | M_GRANT, "R6 aborted to awake");
      step(4);

      // R7 full sleep entry and wake
      k = cyc; host_wr(32'h0000_0004);
      expect_at(k + 2 + SCYC, M_RDY | M_GTS, M_RDY | M_GTS, "R7 last going-to-sleep cycle");
      expect_at(k + 3 + SCYC, M_RDY | M_GTS | M_PS | M_GRANT, 64'h0100_0000, "R7 asleep, code 001");
      step(SCYC + 5);
      k = cyc; pm_sleep_req = 1'b0;
      expect_at(k + 1 + DLY, M_RDY, 64'h0, "R7 waking");
      expect_at(k + 2 + DLY, M_RDY | M_WAKE, M_RDY | M_WAKE, "R7 R8 woke again");
      step(DLY + 4);

      // R9 radio power-down code
      k = cyc; radio_pd = 1'b1;
      expect_at(k + 1, M_PS | M_RDY, 64'h0200_0000 | M_RDY, "R9 radio down code 010");
      step(2);
      radio_pd = 1'b0;
      step(1);

      // R10 radio-kill synchroniser and change pulse
      k = cyc; rfkill_in = 1'b1;
      expect_at(k + 1, M_RFK | M_RFEVT, 64'h0, "R10 not yet synchronised");
      expect_at(k + 2, M_RFK | M_RFEVT, M_RFK | M_RFEVT, "R10 level and pulse");
      expect_at(k + 3, M_RFK | M_RFEVT, M_RFK, "R10 pulse one cycle");
      step(4);
      k = cyc; rfkill_in = 1'b0;
      expect_at(k + 2, M_RFK | M_RFEVT, M_RFEVT, "R10 falling change pulse");
      step(4);

      // R11 clearing init-done returns to low power
      k = cyc; host_wr(32'h0000_0000);
      expect_at(k + 1, M_RDY | M_INIT, M_RDY, "R11 one cycle of ready left");
      expect_at(k + 2, M_RDY | M_GTS | M_PS | M_GRANT, 64'h0100_0000, "R11 low power");
      step(4);

      // R12 power-up timeout
      pm_pwrup_done = 1'b0;
      k = cyc; host_wr(32'h0000_0004);
      expect_at(k + 2 + DLY + TMO, M_PS | M_RDY, 64'h0100_0000, "R12 still waiting");
      expect_at(k + 3 + DLY + TMO, M_PS | M_RDY | M_GRANT, 64'h0300_0000, "R12 error code 011");
      step(DLY + TMO + 6);
      pm_pwrup_done = 1'b1;
      k = cyc; host_wr(32'h0000_0000);
      expect_at(k + 2, M_PS, 64'h0100_0000, "R11 error cleared by init-done low");
      step(4);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule